// File: doc/BRIEF.md
# Multi-Purpose Register Burst Responder

This block is the device-side logic that answers calibration reads from a fixed training register rather than from the memory array. A controller first writes mode register 3 to switch the read source over. Bit 2 of that write turns the training-read mode on or off, and bits 1:0 choose which data location is served. While the mode is on, each read command returns a burst of known alternating bits, one bit per clock on `dq_out`, framed by `dq_valid`. The controller uses these bits to align its capture window.

A read asks for either a full burst of eight beats or a chopped burst of four beats. In the chopped case, column bit 2 chooses the lower or the upper half of the eight-position register. The first beat follows the command after a fixed read latency. After the last beat of any burst, a recovery window must pass before another mode-register write is taken. A write that arrives inside that window, or while a burst is still in flight, is refused. Every refused command, whether a read or a write, produces a single-cycle `err_pulse`.

Top module: `mpr_burst_resp`

## Requirements
- R1: After reset, `dq_valid` and `err_pulse` are low and the training mode is off, so a read then produces no beats and raises the error pulse.
- R2: An accepted write (`mrs_valid`) loads the enable from `mrs_addr[2]` (1 = on) and the location from `mrs_addr[1:0]` (00 = calibration pattern; 01, 10 and 11 are reserved).
- R3: A full read (`rd_chop`=0) with column 000 returns eight beats on consecutive cycles. The first beat comes `RD_LAT` cycles after the command cycle. The beats carry register positions 0 to 7. Position p carries bit p of the register, which is 8'b1010_1010, so the output is 0,1,0,1,0,1,0,1.
- R4: A chopped read with column 000 returns exactly four beats, positions 0 to 3, which gives 0,1,0,1.
- R5: A chopped read with column 100 returns exactly four beats, positions 4 to 7, which gives 0,1,0,1.
- R6: Any other column value is served as column 000. This includes a full read with column 100 and a chopped read with column 010.
- R7: A read while the mode is off, or while a reserved location is selected, produces no beats.
- R8: A read that arrives while a burst is pending or in progress is refused and leaves the running burst unchanged.
- R9: A write is refused, and the mode and location stay as they were, if it arrives while a burst is pending or active, or within `RECOVERY` cycles after the last beat.
- R10: A write made `RECOVERY`+1 or more cycles after the last beat is accepted with no error.
- R11: `err_pulse` is high for exactly one cycle, the cycle after each refused read or write, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_valid | input | 1 | Mode register 3 write strobe |
| mrs_addr | input | 3 | Write payload: [2] enable, [1:0] location |
| rd_valid | input | 1 | Read command strobe |
| rd_chop | input | 1 | 1 = four-beat chopped burst, 0 = eight-beat burst |
| rd_col | input | 3 | Column start address bits [2:0] |
| dq_out | output | 1 | Serial burst data |
| dq_valid | output | 1 | High during each data beat |
| err_pulse | output | 1 | One-cycle flag for a refused command |

## Verification
The hardest point to reach is the edge of the recovery window. A write has to land exactly `RECOVERY` cycles after a last beat, and again one cycle later, and the cycle of that last beat depends on latency, burst length and the command cycle. The bench works out the last-beat cycle for every read it issues and schedules the write relative to it. It then proves that the refused disable left the mode on by issuing a read that must still succeed. Reads issued during a running burst and writes issued mid-burst are placed at fixed offsets inside the latency and data phases.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_DATA} seq_state_t;

  localparam logic [1:0] LOC_CAL  = 2'b00;
  localparam logic [7:0] CAL_WORD = 8'b1010_1010;

  // Register position of the first beat: upper half only for a chopped read at column 100.
  function automatic logic [2:0] first_pos(input logic chop, input logic [2:0] col);
    return (chop && col == 3'b100) ? 3'd4 : 3'd0;
  endfunction

  // Index of the final beat within a burst.
  function automatic logic [2:0] last_beat_idx(input logic chop);
    return chop ? 3'd3 : 3'd7;
  endfunction

  // Position p is bit p of the register word (position 0 = LSB).
  function automatic logic word_bit(input logic [7:0] w, input logic [2:0] p);
    return w[p];
  endfunction

endpackage

// File: rtl/mpr_mode_reg.sv
module mpr_mode_reg
  import mpr_pkg::*;
#(
  parameter int RECOVERY = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mrs_valid,
  input  logic [2:0] mrs_addr,
  input  logic       burst_busy,
  input  logic       burst_last,
  output logic       mpr_en,
  output logic [1:0] mpr_loc,
  output logic       mrs_refuse
);

  localparam int RW = $clog2(RECOVERY + 2);

  logic [RW-1:0] rec_cnt;
  logic          rec_active;
  logic          mrs_take;

  assign rec_active = (rec_cnt != '0);
  assign mrs_refuse = mrs_valid && (burst_busy || rec_active);
  assign mrs_take   = mrs_valid && !mrs_refuse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_cnt <= '0;
      mpr_en  <= 1'b0;
      mpr_loc <= LOC_CAL;
    end else begin
      if (burst_last)      rec_cnt <= RW'(RECOVERY);
      else if (rec_active) rec_cnt <= rec_cnt - 1'b1;
      if (mrs_take) begin
        mpr_en  <= mrs_addr[2];
        mpr_loc <= mrs_addr[1:0];
      end
    end
  end

  AST_REFUSE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_refuse |=> $stable({mpr_en, mpr_loc}));  // R9

  AST_ACCEPT_LOADS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_valid && !burst_busy && !rec_active) |=> (mpr_en == $past(mrs_addr[2]))
      && (mpr_loc == $past(mrs_addr[1:0])));  // R2

  AST_WINDOW_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |=> rec_active || (RECOVERY == 0));  // R9

endmodule

// File: rtl/mpr_burst_seq.sv
module mpr_burst_seq
  import mpr_pkg::*;
#(
  parameter int RD_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       chop,
  input  logic [2:0] col,
  output logic       dq,
  output logic       dv,
  output logic       busy,
  output logic       last
);

  localparam int LW        = $clog2(RD_LAT + 1);
  localparam int WAIT_LOAD = (RD_LAT >= 2) ? RD_LAT - 2 : 0;

  seq_state_t    state;
  logic [LW-1:0] wait_cnt;
  logic [2:0]    beat;
  logic [2:0]    base;
  logic          chop_q;
  logic [2:0]    pos;

  assign pos  = base + beat;
  assign dv   = (state == SQ_DATA);
  assign busy = (state != SQ_IDLE);
  assign last = dv && (beat == last_beat_idx(chop_q));
  assign dq   = dv ? word_bit(CAL_WORD, pos) : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      wait_cnt <= '0;
      beat     <= '0;
      base     <= '0;
      chop_q   <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          chop_q   <= chop;
          base     <= first_pos(chop, col);
          beat     <= '0;
          wait_cnt <= LW'(WAIT_LOAD);
          state    <= (RD_LAT <= 1) ? SQ_DATA : SQ_WAIT;
        end
        SQ_WAIT: begin
          if (wait_cnt == '0) state <= SQ_DATA;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        SQ_DATA: begin
          if (last) state <= SQ_IDLE;
          else      beat  <= beat + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);  // R8

  AST_BEATS_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && !last) |=> dv && (dq != $past(dq)));  // R3

  AST_DV_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv) |-> $past(last));  // R4

endmodule

// File: rtl/mpr_burst_resp.sv
module mpr_burst_resp
  import mpr_pkg::*;
#(
  parameter int RD_LAT   = 4,
  parameter int RECOVERY = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mrs_valid,
  input  logic [2:0] mrs_addr,
  input  logic       rd_valid,
  input  logic       rd_chop,
  input  logic [2:0] rd_col,
  output logic       dq_out,
  output logic       dq_valid,
  output logic       err_pulse
);

  logic       mpr_en;
  logic [1:0] mpr_loc;
  logic       mrs_refuse;
  logic       seq_busy;
  logic       seq_last;
  logic       rd_ok;
  logic       rd_refuse;
  logic       err_q;

  assign rd_ok     = rd_valid && !seq_busy && mpr_en && (mpr_loc == LOC_CAL);
  assign rd_refuse = rd_valid && !rd_ok;

  mpr_mode_reg #(.RECOVERY(RECOVERY)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrs_valid  (mrs_valid),
    .mrs_addr   (mrs_addr),
    .burst_busy (seq_busy),
    .burst_last (seq_last),
    .mpr_en     (mpr_en),
    .mpr_loc    (mpr_loc),
    .mrs_refuse (mrs_refuse)
  );

  mpr_burst_seq #(.RD_LAT(RD_LAT)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rd_ok),
    .chop  (rd_chop),
    .col   (rd_col),
    .dq    (dq_out),
    .dv    (dq_valid),
    .busy  (seq_busy),
    .last  (seq_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= mrs_refuse || rd_refuse;
  end

  assign err_pulse = err_q;

  AST_DATA_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> mpr_en && (mpr_loc == LOC_CAL));  // R7

  AST_ERR_AFTER_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ok) |=> err_pulse);  // R11

  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !mrs_valid) |=> !err_pulse);  // R11

endmodule

// File: tb/mpr_burst_resp_tb.sv
module mpr_burst_resp_tb;

  localparam int RD_LAT   = 4;
  localparam int RECOVERY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrs_valid = 1'b0;
  logic [2:0] mrs_addr = '0;
  logic       rd_valid = 1'b0;
  logic       rd_chop = 1'b0;
  logic [2:0] rd_col = '0;
  logic       dq_out, dq_valid, err_pulse;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_beat = 0;

  int    b_cyc[$];
  bit    b_dat[$];
  string b_tag[$];
  int    e_cyc[$];
  string e_tag[$];

  mpr_burst_resp #(.RD_LAT(RD_LAT), .RECOVERY(RECOVERY)) u_dut (
    .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_addr(mrs_addr),
    .rd_valid(rd_valid), .rd_chop(rd_chop), .rd_col(rd_col),
    .dq_out(dq_out), .dq_valid(dq_valid), .err_pulse(err_pulse)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Monitor: compares beats and error pulses against the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n) begin
      if (b_cyc.size() != 0 && b_cyc[0] == cyc) begin
        check(dq_valid === 1'b1, {b_tag[0], " valid"}, int'(dq_valid), 1);
        check(dq_out === b_dat[0], {b_tag[0], " data"}, int'(dq_out), int'(b_dat[0]));
        void'(b_cyc.pop_front()); void'(b_dat.pop_front()); void'(b_tag.pop_front());
      end else if (dq_valid !== 1'b0) begin
        check(1'b0, "R7 unexpected beat", int'(dq_valid), 0);
      end
      if (e_cyc.size() != 0 && e_cyc[0] == cyc) begin
        check(err_pulse === 1'b1, {e_tag[0], " err"}, int'(err_pulse), 1);
        void'(e_cyc.pop_front()); void'(e_tag.pop_front());
      end else if (err_pulse !== 1'b0) begin
        check(1'b0, "R11 unexpected err", int'(err_pulse), 0);
      end
    end
  end

  // Driver tasks start on a falling edge; the command is sampled at the next rising edge.
  task automatic do_read(input bit chop, input bit [2:0] col, input bit ok, input string tag);
    int c = cyc;
    rd_valid = 1'b1; rd_chop = chop; rd_col = col;
    if (ok) begin
      int n  = chop ? 4 : 8;
      int sp = (chop && col == 3'b100) ? 4 : 0;
      for (int j = 0; j < n; j++) begin
        b_cyc.push_back(c + RD_LAT + j);
        b_dat.push_back(((sp + j) % 2) == 1);
        b_tag.push_back(tag);
      end
      last_beat = c + RD_LAT + n - 1;
    end else begin
      e_cyc.push_back(c + 1); e_tag.push_back(tag);
    end
    @(negedge clk);
    rd_valid = 1'b0; rd_chop = 1'b0; rd_col = '0;
  endtask

  task automatic do_mrs(input bit [2:0] a, input bit ok, input string tag);
    int c = cyc;
    mrs_valid = 1'b1; mrs_addr = a;
    if (!ok) begin e_cyc.push_back(c + 1); e_tag.push_back(tag); end
    @(negedge clk);
    mrs_valid = 1'b0; mrs_addr = '0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic settle();
    wait_until(last_beat + RECOVERY + 2);
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_valid === 1'b0, "R1 dq_valid after reset", int'(dq_valid), 0);
        check(err_pulse === 1'b0, "R1 err after reset", int'(err_pulse), 0);
        do_read(1'b0, 3'b000, 1'b0, "R1 read before enable");
        repeat (3) @(negedge clk);
        do_mrs(3'b100, 1'b1, "R2 enable calibration");
        repeat (2) @(negedge clk);
        do_read(1'b0, 3'b000, 1'b1, "R3 full burst");
        settle();
        do_read(1'b1, 3'b000, 1'b1, "R4 chop low");
        settle();
        do_read(1'b1, 3'b100, 1'b1, "R5 chop high");
        settle();
        do_read(1'b0, 3'b100, 1'b1, "R6 full col 100");
        settle();
        do_read(1'b1, 3'b010, 1'b1, "R6 chop col 010");
        settle();
        // Reads and writes while a burst is pending and while it is active
        do_read(1'b0, 3'b000, 1'b1, "R8 first burst");
        do_read(1'b1, 3'b100, 1'b0, "R8 read in latency");
        wait_until(last_beat - 3);
        do_read(1'b0, 3'b000, 1'b0, "R8 read in data");
        do_mrs(3'b000, 1'b0, "R9 write during burst");
        // Write at the final cycle of the recovery window
        wait_until(last_beat + RECOVERY);
        do_mrs(3'b000, 1'b0, "R9 write at window end");
        repeat (2) @(negedge clk);
        do_read(1'b1, 3'b000, 1'b1, "R9 mode kept after refusal");
        // First cycle after the window: accepted
        wait_until(last_beat + RECOVERY + 1);
        do_mrs(3'b101, 1'b1, "R10 write after window");
        repeat (2) @(negedge clk);
        do_read(1'b0, 3'b000, 1'b0, "R7 reserved location");
        repeat (2) @(negedge clk);
        do_mrs(3'b000, 1'b1, "R2 disable");
        repeat (2) @(negedge clk);
        do_read(1'b1, 3'b100, 1'b0, "R7 read when disabled");
        repeat (2) @(negedge clk);
        do_mrs(3'b100, 1'b1, "R2 re-enable");
        repeat (2) @(negedge clk);
        do_read(1'b0, 3'b000, 1'b1, "R3 burst after re-enable");
        settle();
        check(b_cyc.size() == 0, "R3 beats outstanding", b_cyc.size(), 0);
        check(e_cyc.size() == 0, "R11 errors outstanding", e_cyc.size(), 0);
        done = 1;
      end
      begin
        repeat (5000) @(negedge clk);
        if (!done) check(1'b0, "R11 watchdog expired", cyc, 5000);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule